// File: doc/BRIEF.md
# Soft-Start and VID Reference Sequencer

This block produces the digital reference code that drives the regulation DAC of a multiphase buck controller. The code counts in units of 6.25 mV. Start-up has two stages. Once the block is enabled, the reference climbs from zero to a fixed 1.100 V boot level, one unit for each pulse on the soft-start tick input, and waits there. After the voltage-identification (VID) input is flagged valid, the reference slews to the level that the VID code requests. It moves one unit per tick and may move up or down.

The VID code can change while the output is regulating. The reference then slews to the new target instead of jumping. Two things are reported. A done flag marks the first time the reference reaches its target after start-up. A shutdown flag latches when a valid VID carries an OFF code. That latch holds the reference at zero until the synchronous reset is applied, whatever the enable and VID inputs do.

Top module: `vref_sequencer`

## Requirements
- R1: While `rst_n` is low, and at the first clock edge after it, `ref_code` is 0 and `ss_done` and `off_shut` are 0.
- R2: Once `enable` is high, each tick raises `ref_code` by one, up to 176 (1.100 V). It then holds at 176 for as long as `vid_valid` stays low.
- R3: `ref_code` changes by at most one per clock edge, and it changes only at a clock edge where `tick` is high, except when it is cleared to zero.
- R4: For a non-OFF 8-bit VID value `v`, read as unsigned, the target code is 256 − v. Code 0 is 1.600 V, and each higher code is 6.25 mV lower.
- R5: Once the boot level is reached and `vid_valid` is high, each tick moves `ref_code` one step toward the target, either up or down. It stops at the target and follows VID changes the same way.
- R6: A VID whose bits [7:3] are all ones is OFF. When such a code is seen with `enable` and `vid_valid` both high, `off_shut` rises at that clock edge and `ref_code` becomes 0. Both then hold until `rst_n` is low. An OFF code with `vid_valid` low is ignored.
- R7: `ss_done` rises at the clock edge after the one where `ref_code` first equals the target in the tracking phase. It stays high through later VID changes.
- R8: Lowering `enable` clears `ref_code` and `ss_done` at the next edge. Raising it again restarts the boot ramp from 0.
- R9: While tracking, `ref_code` holds its value as long as `vid_valid` is low, even when ticks arrive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Start request; low returns to idle |
| vid | input | 8 | Voltage-identification code |
| vid_valid | input | 1 | VID code is valid |
| tick | input | 1 | Soft-start rate pulse, one step per high cycle |
| ref_code | output | 9 | Reference code, 6.25 mV per unit |
| ss_done | output | 1 | Target first reached after start-up |
| off_shut | output | 1 | Latched shutdown from an OFF code |

## Verification
Each result has a fixed latency. `ref_code` moves at the same clock edge that samples `tick`, and the enable and OFF effects also appear at the edge that samples them. `ss_done` comes one edge later, because it is registered from the comparison of reference and target. The bench drives every input at a falling edge and reads `ref_code` and `off_shut` at the next falling edge. It waits one more falling edge before it reads `ss_done`. Expected values come from a step-toward-goal model in the bench. The model is swept over the boot ramp, over every non-OFF VID code, over large steps in both directions, and over all eight OFF codes.

// File: rtl/vref_pkg.sv
// Package: shared state encoding for the reference sequencer.
// Assumes: one sequencer state register; encoding is not externally visible.
package vref_pkg;
    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_BOOT  = 2'd1,
        SEQ_TRACK = 2'd2,
        SEQ_OFF   = 2'd3
    } seq_state_t;
endpackage

// File: rtl/vid_decode.sv
// vid_decode: turns a VID word into a reference target and an OFF flag.
// Assumes: target = TOP_CODE - vid; OFF when the OFF_BITS upper bits are all ones.
module vid_decode #(
    parameter int VID_W    = 8,
    parameter int REF_W    = 9,
    parameter int TOP_CODE = 256,
    parameter int OFF_BITS = 5
) (
    input  logic [VID_W-1:0] vid_i,
    output logic [REF_W-1:0] target_o,
    output logic             off_code_o
);
    localparam logic [REF_W-1:0] TOP_VAL = REF_W'(TOP_CODE);

    // Linear map: each code step lowers the target by one unit.
    always_comb begin
        target_o   = TOP_VAL - REF_W'(vid_i);
        off_code_o = &vid_i[VID_W-1 -: OFF_BITS];
    end
endmodule

// File: rtl/ref_stepper.sv
// ref_stepper: holds the reference code and moves it one unit toward a goal per step enable.
// Assumes: clear has priority; goal may lie above or below the current code.
module ref_stepper #(
    parameter int REF_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             step_en_i,
    input  logic [REF_W-1:0] goal_i,
    output logic [REF_W-1:0] ref_o
);
    localparam logic [REF_W-1:0] ONE = REF_W'(1);

    logic [REF_W-1:0] ref_q;

    // Reference register: clear, step up, step down or hold.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i)
            ref_q <= '0;
        else if (step_en_i && (ref_q < goal_i))
            ref_q <= ref_q + ONE;
        else if (step_en_i && (ref_q > goal_i))
            ref_q <= ref_q - ONE;
    end

    assign ref_o = ref_q;

    AST_SINGLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i) |=> (ref_q == $past(ref_q) || ref_q == $past(ref_q) + ONE ||
                      ref_q == $past(ref_q) - ONE)); // R3
    AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && !step_en_i) |=> $stable(ref_q)); // R3
endmodule

// File: rtl/seq_ctrl.sv
// seq_ctrl: sequences idle, boot ramp, tracking and latched OFF; derives done flag.
// Assumes: ref_i is the stepper output; OFF leaves only through rst_n.
module seq_ctrl
    import vref_pkg::*;
#(
    parameter int REF_W     = 9,
    parameter int BOOT_CODE = 176
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable_i,
    input  logic             vid_valid_i,
    input  logic             off_code_i,
    input  logic             tick_i,
    input  logic [REF_W-1:0] ref_i,
    input  logic [REF_W-1:0] target_i,
    output logic             clr_o,
    output logic             step_en_o,
    output logic [REF_W-1:0] goal_o,
    output logic             done_o,
    output logic             off_o
);
    localparam logic [REF_W-1:0] BOOT_VAL = REF_W'(BOOT_CODE);

    seq_state_t state_q, state_d;
    logic       off_hit;
    logic       done_q;

    // Next-state selection.
    always_comb begin
        off_hit = enable_i && vid_valid_i && off_code_i;
        state_d = state_q;
        case (state_q)
            SEQ_IDLE: begin
                if (off_hit)       state_d = SEQ_OFF;
                else if (enable_i) state_d = SEQ_BOOT;
            end
            SEQ_BOOT: begin
                if (off_hit)                              state_d = SEQ_OFF;
                else if (!enable_i)                       state_d = SEQ_IDLE;
                else if (ref_i == BOOT_VAL && vid_valid_i) state_d = SEQ_TRACK;
            end
            SEQ_TRACK: begin
                if (off_hit)        state_d = SEQ_OFF;
                else if (!enable_i) state_d = SEQ_IDLE;
            end
            default: state_d = SEQ_OFF;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SEQ_IDLE;
        else        state_q <= state_d;
    end

    // Done flag: set on first match while tracking, cleared on leaving tracking.
    always_ff @(posedge clk) begin
        if (!rst_n)
            done_q <= 1'b0;
        else if (state_d != SEQ_TRACK)
            done_q <= 1'b0;
        else if (state_q == SEQ_TRACK && vid_valid_i && ref_i == target_i)
            done_q <= 1'b1;
    end

    // Stepper controls: goal, step gating and clear.
    always_comb begin
        goal_o    = (state_q == SEQ_TRACK) ? target_i : BOOT_VAL;
        step_en_o = tick_i && ((state_q == SEQ_BOOT) ||
                               (state_q == SEQ_TRACK && vid_valid_i));
        clr_o     = (state_q == SEQ_IDLE) || (state_q == SEQ_OFF) ||
                    !enable_i || off_hit;
    end

    assign done_o = done_q;
    assign off_o  = (state_q == SEQ_OFF);

    AST_OFF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        off_o |=> off_o); // R6
    AST_BOOT_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SEQ_BOOT) |-> (ref_i <= BOOT_VAL)); // R2
    AST_DONE_AT_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_q) |-> $past(ref_i == target_i)); // R7
endmodule

// File: rtl/vref_sequencer.sv
// vref_sequencer: top of the soft-start and VID reference sequencer.
// Assumes: tick is a single-cycle pulse per soft-start step; inputs synchronous to clk.
module vref_sequencer #(
    parameter int VID_W     = 8,
    parameter int REF_W     = 9,
    parameter int TOP_CODE  = 256,
    parameter int BOOT_CODE = 176,
    parameter int OFF_BITS  = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [VID_W-1:0] vid,
    input  logic             vid_valid,
    input  logic             tick,
    output logic [REF_W-1:0] ref_code,
    output logic             ss_done,
    output logic             off_shut
);
    logic [REF_W-1:0] target;
    logic             off_code;
    logic             clr;
    logic             step_en;
    logic [REF_W-1:0] goal;

    vid_decode #(
        .VID_W(VID_W), .REF_W(REF_W), .TOP_CODE(TOP_CODE), .OFF_BITS(OFF_BITS)
    ) u_dec (
        .vid_i(vid), .target_o(target), .off_code_o(off_code)
    );

    seq_ctrl #(
        .REF_W(REF_W), .BOOT_CODE(BOOT_CODE)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .enable_i(enable), .vid_valid_i(vid_valid),
        .off_code_i(off_code), .tick_i(tick), .ref_i(ref_code), .target_i(target),
        .clr_o(clr), .step_en_o(step_en), .goal_o(goal),
        .done_o(ss_done), .off_o(off_shut)
    );

    ref_stepper #(
        .REF_W(REF_W)
    ) u_step (
        .clk(clk), .rst_n(rst_n), .clr_i(clr), .step_en_i(step_en),
        .goal_i(goal), .ref_o(ref_code)
    );

    AST_OFF_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        off_shut |-> (ref_code == '0)); // R6
endmodule

// File: tb/tb_vref_sequencer.sv
module tb_vref_sequencer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b0;
    logic [7:0] vid = 8'd0;
    logic       vid_valid = 1'b0;
    logic       tick = 1'b0;
    logic [8:0] ref_code;
    logic       ss_done;
    logic       off_shut;

    int n_chk = 0;
    int n_bad = 0;
    int model = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    vref_sequencer dut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .vid(vid),
        .vid_valid(vid_valid), .tick(tick), .ref_code(ref_code),
        .ss_done(ss_done), .off_shut(off_shut)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick_once();
        @(negedge clk); tick = 1'b1;
        @(negedge clk); tick = 1'b0;
    endtask

    function automatic int tgt(input int v);
        return 256 - v;
    endfunction

    // Ticks until the model reaches goal, checking each step.
    task automatic slew_to(input int goal, input string req);
        while (model != goal) begin
            model += (goal > model) ? 1 : -1;
            tick_once();
            check(req, int'(ref_code), model);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0; enable = 1'b0; vid_valid = 1'b0; vid = 8'd0; tick = 1'b0;
        @(negedge clk); @(negedge clk); rst_n = 1'b1;
        model = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        @(negedge clk); @(negedge clk);
        check("R1 ref", int'(ref_code), 0);
        check("R1 done", int'(ss_done), 0);
        check("R1 off", int'(off_shut), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 ref after release", int'(ref_code), 0);

        // R8: ticks while disabled have no effect
        repeat (3) tick_once();
        check("R8 disabled hold", int'(ref_code), 0);

        // R2: boot ramp to 176 with VID not valid
        enable = 1'b1; vid = 8'd0;
        @(negedge clk);
        slew_to(176, "R2 boot ramp");
        repeat (4) tick_once();
        check("R2 boot hold", int'(ref_code), 176);
        check("R7 done low in boot", int'(ss_done), 0);

        // R5: climb to 1.600 V once valid
        vid_valid = 1'b1;
        @(negedge clk);
        slew_to(255, "R5 climb");
        @(negedge clk);
        check("R7 done before target", int'(ss_done), 0);
        slew_to(256, "R5 climb");
        @(negedge clk);
        check("R7 done at target", int'(ss_done), 1);
        tick_once();
        check("R5 stop at target", int'(ref_code), 256);

        // R4: sweep every non-OFF code on the fly
        for (int v = 1; v < 248; v++) begin
            @(negedge clk); vid = 8'(v);
            model = tgt(v);
            tick_once();
            check("R4 decode", int'(ref_code), model);
        end
        @(negedge clk);
        check("R7 done held", int'(ss_done), 1);

        // R5: large steps both directions
        vid = 8'h10; slew_to(tgt(16), "R5 up slew");
        vid = 8'hC0; slew_to(tgt(192), "R5 down slew");

        // R9: valid low holds the reference
        vid_valid = 1'b0; vid = 8'h00;
        repeat (5) tick_once();
        check("R9 hold", int'(ref_code), model);

        // R8: disable clears, re-enable restarts boot
        @(negedge clk); enable = 1'b0;
        @(negedge clk);
        check("R8 ref cleared", int'(ref_code), 0);
        @(negedge clk);
        check("R8 done cleared", int'(ss_done), 0);
        enable = 1'b1; model = 0;
        @(negedge clk);
        slew_to(3, "R8 restart ramp");

        // R6: OFF codes
        for (int k = 0; k < 8; k++) begin
            do_reset();
            enable = 1'b1; vid = 8'd0;
            @(negedge clk);
            slew_to(10, "R6 pre-ramp");
            vid = 8'hF8 + 8'(k); vid_valid = 1'b0;
            @(negedge clk);
            check("R6 off ignored when invalid", int'(off_shut), 0);
            check("R6 ref kept when invalid", int'(ref_code), 10);
            vid_valid = 1'b1;
            @(negedge clk);
            check("R6 off set", int'(off_shut), 1);
            check("R6 ref zero", int'(ref_code), 0);
            enable = 1'b0; @(negedge clk); enable = 1'b1; vid = 8'd0;
            repeat (3) tick_once();
            check("R6 off held", int'(off_shut), 1);
            check("R6 ref held zero", int'(ref_code), 0);
            rst_n = 1'b0; @(negedge clk); rst_n = 1'b1;
            check("R6 off cleared by reset", int'(off_shut), 0);
        end

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule